// File: doc/BRIEF.md
# Transmit VLAN Tag Editor

This block is a byte-wide streaming stage placed in front of a transmit MAC. It edits IEEE 802.1Q tags in each outgoing frame. A 2-bit code picks one of four actions: keep the frame as it is, strip the tag, add a new tag, or overwrite the tag control information of an existing tag. One code acts on the outer tag and a second code, with the same encoding, acts on the inner tag of a double-tagged frame. The 16-bit tag value for each level comes in on a side port next to its code. The stage samples both codes and both values with the first byte of each frame.

The outer tag sits directly after the source address, at byte offset 12 (parameter `TAG_OFFSET`). The inner tag follows it at offset 16. The two levels are built as two identical editor stages in series. The inner stage therefore sees offsets in the frame as the outer stage has already rewritten it. A tag is the TPID 0x8100 followed by the 16-bit TCI. Before a strip or an overwrite, the stage checks that the two bytes at the tag offset are 0x8100. If they are not, it leaves the frame untouched and raises an error pulse for that level.

When either level changes the frame, the last byte of the frame carries a flag. The flag tells the CRC stage downstream to recompute the frame check sequence. To open the 4-byte gap for an added tag, the stage stalls the upstream side. Stripping a tag leaves holes in the output valid signal. The output has no backpressure. Edited frames are assumed to be at least 24 bytes long.

Top module: `vlan_tag_stage`

## Requirements
- R1: With both codes at 00 (keep), every output frame is byte-for-byte identical to its input frame and arrives with no hole in the output valid signal.
- R2: Outer code 10 (add) places 0x81, 0x00, tag[15:8], tag[7:0] at byte offsets 12 to 15. The original bytes from offset 12 onward follow these four bytes.
- R3: Outer code 01 (strip), on a frame whose bytes 12 and 13 are 0x81 and 0x00, removes bytes 12 to 15 and leaves every other byte in order.
- R4: Outer code 11 (overwrite), on a frame whose bytes 12 and 13 are 0x81 and 0x00, replaces bytes 14 and 15 with tag[15:8] and tag[7:0]. The frame length stays the same.
- R5: When the outer code is 01 or 11 and bytes 12 and 13 are not 0x81 0x00, the frame passes through unchanged. In that case tag_err_o[0] pulses high for exactly one cycle.
- R6: The inner code uses the same encoding and acts at offset 16 of the frame as it leaves the outer edit. A failed TPID check on the inner level pulses tag_err_o[1] instead.
- R7: Each tag addition holds in_ready_o low for exactly 4 cycles of the frame, given that the input is presented without pause.
- R8: Each outer strip leaves exactly 4 cycles inside the output frame in which out_valid_o is low.
- R9: On the beat with out_last_o high, out_fcs_redo_o is 1 exactly when at least one level changed the frame, and 0 otherwise.
- R10: The codes and tag values are sampled with the first byte of a frame. Any change to them later in the same frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Input byte ends the frame |
| in_ready_o | output | 1 | Stage accepts the input byte this cycle |
| outer_ctl_i | input | 2 | Outer tag code: 00 keep, 01 strip, 10 add, 11 overwrite |
| outer_tag_i | input | 16 | Outer TCI for add or overwrite |
| inner_ctl_i | input | 2 | Inner tag code, same encoding |
| inner_tag_i | input | 16 | Inner TCI for add or overwrite |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Output byte ends the frame |
| out_fcs_redo_o | output | 1 | With the last byte: the frame was edited, recompute the CRC |
| tag_err_o | output | 2 | One-cycle pulse per failed TPID check, bit 0 outer, bit 1 inner |

## Verification
Frames with no tag, one tag and two tags are each run through every code at each level. A frame with no tag under strip or overwrite separates the TPID check from a blind edit. A frame with one tag under an inner edit shows that the inner level looks at offset 16 and not at the outer tag. Adding at both levels to an untagged frame, and stripping the outer tag while overwriting the inner one, show that the inner stage reads offsets in the already rewritten frame. Stall and hole counts per frame separate the add, strip and keep paths in time. A run that changes the codes after the first byte shows that the codes are sampled once per frame.

// File: rtl/vlan_edit_pkg.sv
package vlan_edit_pkg;

  typedef enum logic [1:0] {
    OP_KEEP  = 2'b00,
    OP_STRIP = 2'b01,
    OP_ADD   = 2'b10,
    OP_SWAP  = 2'b11
  } tag_op_e;

  localparam logic [15:0] TPID_Q = 16'h8100;
  localparam int unsigned TAG_BYTES = 4;

  typedef struct packed {
    logic [7:0] data;
    logic       last;
    logic       mod;
  } beat_t;

endpackage

// File: rtl/vlan_beat_reg.sv
module vlan_beat_reg
  import vlan_edit_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  beat_t beat_i,
  input  logic  ready_i,
  output logic  adv_o,
  output logic  valid_o,
  output beat_t beat_o
);

  logic  valid_q;
  beat_t beat_q;

  assign adv_o   = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign beat_o  = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (adv_o) begin
      valid_q <= load_i;
      beat_q  <= beat_i;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(beat_o)); // R7

endmodule

// File: rtl/vlan_tag_editor.sv
module vlan_tag_editor
  import vlan_edit_pkg::*;
#(
  parameter int unsigned OFFSET = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  beat_t       in_beat_i,
  output logic        in_ready_o,
  input  logic [1:0]  ctl_i,
  input  logic [15:0] tag_i,
  input  logic        out_ready_i,
  output logic        out_valid_o,
  output beat_t       out_beat_o,
  output logic        err_o
);

  localparam int unsigned POS_W = $clog2(OFFSET + 1);

  typedef enum logic [2:0] {S_HEAD, S_GEN, S_HOLD, S_FLUSH, S_DROP, S_TAIL} st_e;

  st_e              st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;
  tag_op_e          op_q, op_d;
  logic [15:0]      tag_q, tag_d;
  logic [15:0]      hold_q, hold_d;
  logic [1:0]       idx_q, idx_d;
  logic [1:0]       rep_q, rep_d;
  logic             mod_q, mod_d;
  logic             err_q, err_d;

  logic  emit, adv, acc, at_off, tpid_ok;
  beat_t emit_b;

  assign acc     = in_valid_i && in_ready_o;
  assign at_off  = (pos_q == POS_W'(OFFSET));
  assign tpid_ok = ({hold_q[15:8], in_beat_i.data} == TPID_Q);
  assign err_o   = err_q;

  always_comb begin
    st_d       = st_q;
    pos_d      = pos_q;
    op_d       = op_q;
    tag_d      = tag_q;
    hold_d     = hold_q;
    idx_d      = idx_q;
    rep_d      = rep_q;
    mod_d      = mod_q;
    err_d      = 1'b0;
    in_ready_o = 1'b0;
    emit       = 1'b0;
    emit_b     = in_beat_i;
    emit_b.mod = in_beat_i.mod | mod_q;

    unique case (st_q)
      S_HEAD: begin
        if (at_off && op_q == OP_ADD) begin
          // first TPID byte goes out while the offset byte waits
          if (in_valid_i && adv) begin
            emit        = 1'b1;
            emit_b.data = TPID_Q[15:8];
            emit_b.last = 1'b0;
            emit_b.mod  = 1'b1;
            idx_d       = 2'd1;
            mod_d       = 1'b1;
            st_d        = S_GEN;
          end
        end else if (at_off && (op_q == OP_STRIP || op_q == OP_SWAP)) begin
          in_ready_o = 1'b1;
          if (in_valid_i) begin
            hold_d[15:8] = in_beat_i.data;
            st_d         = S_HOLD;
          end
        end else begin
          in_ready_o = adv;
          if (acc) begin
            emit = 1'b1;
            if (pos_q == '0) begin
              op_d  = tag_op_e'(ctl_i);
              tag_d = tag_i;
            end
            if (in_beat_i.last) begin
              pos_d = '0;
              mod_d = 1'b0;
            end else if (!at_off) begin
              pos_d = pos_q + 1'b1;
            end
          end
        end
      end

      S_GEN: begin
        if (adv) begin
          emit        = 1'b1;
          emit_b.last = 1'b0;
          emit_b.mod  = 1'b1;
          unique case (idx_q)
            2'd0:    emit_b.data = TPID_Q[15:8];
            2'd1:    emit_b.data = TPID_Q[7:0];
            2'd2:    emit_b.data = tag_q[15:8];
            default: emit_b.data = tag_q[7:0];
          endcase
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            rep_d = 2'd0;
            st_d  = S_TAIL;
          end
        end
      end

      S_HOLD: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          hold_d[7:0] = in_beat_i.data;
          idx_d       = 2'd0;
          if (tpid_ok) begin
            mod_d = 1'b1;
            if (op_q == OP_STRIP) begin
              st_d = S_DROP;
            end else begin
              rep_d = 2'd2;
              st_d  = S_FLUSH;
            end
          end else begin
            err_d = 1'b1;
            rep_d = 2'd0;
            st_d  = S_FLUSH;
          end
        end
      end

      S_FLUSH: begin
        if (adv) begin
          emit        = 1'b1;
          emit_b.last = 1'b0;
          emit_b.mod  = mod_q;
          emit_b.data = idx_q[0] ? hold_q[7:0] : hold_q[15:8];
          idx_d       = idx_q + 2'd1;
          if (idx_q[0]) st_d = S_TAIL;
        end
      end

      S_DROP: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          idx_d = idx_q + 2'd1;
          if (idx_q[0]) begin
            rep_d = 2'd0;
            st_d  = S_TAIL;
          end
        end
      end

      default: begin // S_TAIL
        in_ready_o = adv;
        if (acc) begin
          emit = 1'b1;
          if (rep_q != 2'd0) begin
            emit_b.data = rep_q[1] ? tag_q[15:8] : tag_q[7:0];
            rep_d       = rep_q - 2'd1;
          end
          if (in_beat_i.last) begin
            pos_d = '0;
            mod_d = 1'b0;
            st_d  = S_HEAD;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_HEAD;
      pos_q  <= '0;
      op_q   <= OP_KEEP;
      tag_q  <= '0;
      hold_q <= '0;
      idx_q  <= '0;
      rep_q  <= '0;
      mod_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      op_q   <= op_d;
      tag_q  <= tag_d;
      hold_q <= hold_d;
      idx_q  <= idx_d;
      rep_q  <= rep_d;
      mod_q  <= mod_d;
      err_q  <= err_d;
    end
  end

  vlan_beat_reg u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (emit),
    .beat_i  (emit_b),
    .ready_i (out_ready_i),
    .adv_o   (adv),
    .valid_o (out_valid_o),
    .beat_o  (out_beat_o)
  );

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q); // R5
  AST_ERR_UNMOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !mod_q); // R5
  AST_ADD_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_GEN) && adv |=> out_valid_o && out_beat_o.mod); // R9
  AST_GAP_NOT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_GEN || st_q == S_FLUSH) && adv |=> out_valid_o && !out_beat_o.last); // R2

endmodule

// File: rtl/vlan_tag_stage.sv
module vlan_tag_stage
  import vlan_edit_pkg::*;
#(
  parameter int unsigned TAG_OFFSET = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  output logic        in_ready_o,
  input  logic [1:0]  outer_ctl_i,
  input  logic [15:0] outer_tag_i,
  input  logic [1:0]  inner_ctl_i,
  input  logic [15:0] inner_tag_i,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_last_o,
  output logic        out_fcs_redo_o,
  output logic [1:0]  tag_err_o
);

  localparam int unsigned LEVELS = 2;

  logic [LEVELS:0] lvl_v, lvl_r;
  beat_t           lvl_b [LEVELS+1];

  // inner code rides with the frame until the inner level sees its first byte
  logic        first_q;
  logic [1:0]  ictl_q;
  logic [15:0] itag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      ictl_q  <= '0;
      itag_q  <= '0;
    end else if (in_valid_i && in_ready_o) begin
      first_q <= in_last_i;
      if (first_q) begin
        ictl_q <= inner_ctl_i;
        itag_q <= inner_tag_i;
      end
    end
  end

  assign lvl_v[0]      = in_valid_i;
  assign lvl_b[0]      = '{data: in_data_i, last: in_last_i, mod: 1'b0};
  assign in_ready_o    = lvl_r[0];
  assign lvl_r[LEVELS] = 1'b1;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    logic [1:0]  ctl;
    logic [15:0] tag;
    if (g == 0) begin : g_outer
      assign ctl = outer_ctl_i;
      assign tag = outer_tag_i;
    end else begin : g_inner
      assign ctl = ictl_q;
      assign tag = itag_q;
    end
    vlan_tag_editor #(.OFFSET(TAG_OFFSET + TAG_BYTES * g)) u_ed (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .in_valid_i  (lvl_v[g]),
      .in_beat_i   (lvl_b[g]),
      .in_ready_o  (lvl_r[g]),
      .ctl_i       (ctl),
      .tag_i       (tag),
      .out_ready_i (lvl_r[g+1]),
      .out_valid_o (lvl_v[g+1]),
      .out_beat_o  (lvl_b[g+1]),
      .err_o       (tag_err_o[g])
    );
  end

  assign out_valid_o    = lvl_v[LEVELS];
  assign out_data_o     = lvl_b[LEVELS].data;
  assign out_last_o     = lvl_b[LEVELS].last;
  assign out_fcs_redo_o = lvl_v[LEVELS] & lvl_b[LEVELS].last & lvl_b[LEVELS].mod;

  AST_ERR_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_err_o[0] |-> !tag_err_o[1]); // R6

endmodule

// File: tb/sim_vlan_tag_stage.sv
module sim_vlan_tag_stage;
  localparam int CLK_PERIOD = 10;
  localparam int TOFF = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [1:0]  octl = '0, ictl = '0;
  logic [15:0] otag = '0, itag = '0;
  logic        out_valid, out_last, out_redo;
  logic [7:0]  out_data;
  logic [1:0]  tag_err;

  vlan_tag_stage #(.TAG_OFFSET(TOFF)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
    .outer_ctl_i(octl), .outer_tag_i(otag), .inner_ctl_i(ictl), .inner_tag_i(itag),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_fcs_redo_o(out_redo), .tag_err_o(tag_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx_q[$], exp_q[$], out_all[$];
  int npk = 0, gaps = 0, e0 = 0, e1 = 0;
  logic last_redo = 1'b0, in_pk = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tag_err[0]) e0++;
      if (tag_err[1]) e1++;
      if (out_valid) begin
        out_all.push_back(out_data);
        in_pk = 1'b1;
        if (out_last) begin
          last_redo = out_redo;
          in_pk = 1'b0;
          npk++;
        end
      end else if (in_pk) begin
        gaps++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: run reached %0d cycles, expected fewer", 100000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic build(input int ntag, input logic [15:0] t1, input logic [15:0] t2);
    tx_q.delete();
    for (int i = 0; i < 12; i++) tx_q.push_back(8'(8'h10 + i));
    if (ntag >= 1) begin
      tx_q.push_back(8'h81); tx_q.push_back(8'h00);
      tx_q.push_back(t1[15:8]); tx_q.push_back(t1[7:0]);
    end
    if (ntag >= 2) begin
      tx_q.push_back(8'h81); tx_q.push_back(8'h00);
      tx_q.push_back(t2[15:8]); tx_q.push_back(t2[7:0]);
    end
    tx_q.push_back(8'h08); tx_q.push_back(8'h00);
    while (tx_q.size() < 40) tx_q.push_back(8'(160 + tx_q.size()));
  endtask

  task automatic apply(input logic [1:0] op, input logic [15:0] t, input int off,
                       output bit changed, output bit err);
    changed = 1'b0; err = 1'b0;
    if (op == 2'b10) begin
      exp_q.insert(off, 8'h81); exp_q.insert(off + 1, 8'h00);
      exp_q.insert(off + 2, t[15:8]); exp_q.insert(off + 3, t[7:0]);
      changed = 1'b1;
    end else if (op != 2'b00) begin
      if (exp_q[off] == 8'h81 && exp_q[off + 1] == 8'h00) begin
        changed = 1'b1;
        if (op == 2'b01) begin
          for (int k = 0; k < 4; k++) exp_q.delete(off);
        end else begin
          exp_q[off + 2] = t[15:8];
          exp_q[off + 3] = t[7:0];
        end
      end else begin
        err = 1'b1;
      end
    end
  endtask

  task automatic send(input logic [1:0] oc, input logic [15:0] ot, input logic [1:0] ic,
                      input logic [15:0] it, input bit scramble, output int stalls);
    bit r;
    stalls = 0;
    @(negedge clk);
    for (int i = 0; i < tx_q.size(); i++) begin
      in_valid = 1'b1;
      in_data  = tx_q[i];
      in_last  = (i == tx_q.size() - 1);
      if (i == 0) begin
        octl = oc; otag = ot; ictl = ic; itag = it;
      end else if (scramble) begin
        octl = 2'b01; otag = 16'hFFFF; ictl = 2'b10; itag = 16'hFFFF;
      end
      r = 1'b0;
      while (!r) begin
        #1;
        r = in_ready;
        @(negedge clk);
        if (!r) stalls++;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run(input string req, input logic [1:0] oc, input logic [15:0] ot,
                     input logic [1:0] ic, input logic [15:0] it, input bit scramble,
                     input int exp_stall, input int exp_gap);
    int n0, g0, a0, b0, s0, st, len, bad;
    bit c1, r1, c2, r2;
    n0 = npk; g0 = gaps; a0 = e0; b0 = e1; s0 = out_all.size();
    exp_q = tx_q;
    apply(oc, ot, TOFF, c1, r1);
    apply(ic, it, TOFF + 4, c2, r2);
    send(oc, ot, ic, it, scramble, st);
    while (npk == n0) @(negedge clk);
    repeat (4) @(negedge clk);
    len = out_all.size() - s0;
    chk(len == exp_q.size(), req, $sformatf("frame length got %0d exp %0d", len, exp_q.size()));
    bad = -1;
    if (len == exp_q.size())
      for (int i = len - 1; i >= 0; i--) if (out_all[s0 + i] != exp_q[i]) bad = i;
    chk(bad < 0, req, $sformatf("byte %0d got %02h exp %02h", bad,
        (bad < 0) ? 8'h00 : out_all[s0 + bad], (bad < 0) ? 8'h00 : exp_q[bad]));
    chk(last_redo == (c1 | c2), "R9", $sformatf("fcs redo got %0b exp %0b", last_redo, c1 | c2));
    chk((e0 - a0) == int'(r1), "R5", $sformatf("outer err pulses got %0d exp %0d", e0 - a0, r1));
    chk((e1 - b0) == int'(r2), "R6", $sformatf("inner err pulses got %0d exp %0d", e1 - b0, r2));
    if (exp_stall >= 0)
      chk(st == exp_stall, "R7", $sformatf("input stalls got %0d exp %0d", st, exp_stall));
    if (exp_gap >= 0)
      chk((gaps - g0) == exp_gap, "R8", $sformatf("output holes got %0d exp %0d", gaps - g0, exp_gap));
  endtask

  task automatic t_reset;
    #1;
    chk(out_valid == 1'b0, "R1", $sformatf("reset out_valid got %0b exp 0", out_valid));
    chk(in_ready == 1'b1, "R1", $sformatf("reset in_ready got %0b exp 1", in_ready));
    chk(tag_err == 2'b00, "R5", $sformatf("reset tag_err got %0b exp 00", tag_err));
  endtask

  task automatic t_keep;
    build(0, 16'h0, 16'h0);    run("R1", 2'b00, 16'h1234, 2'b00, 16'h5678, 1'b0, 0, 0);
    build(2, 16'h2001, 16'h3002); run("R1", 2'b00, 16'h0, 2'b00, 16'h0, 1'b0, 0, 0);
  endtask

  task automatic t_add;
    build(0, 16'h0, 16'h0);    run("R2", 2'b10, 16'hA123, 2'b00, 16'h0, 1'b0, 4, 0);
    build(1, 16'h2064, 16'h0); run("R2", 2'b10, 16'h0FED, 2'b00, 16'h0, 1'b0, 4, 0);
  endtask

  task automatic t_strip;
    build(1, 16'h2064, 16'h0); run("R3", 2'b01, 16'h0, 2'b00, 16'h0, 1'b0, 0, 4);
  endtask

  task automatic t_swap;
    build(1, 16'h2064, 16'h0); run("R4", 2'b11, 16'h5E6F, 2'b00, 16'h0, 1'b0, -1, -1);
  endtask

  task automatic t_bad_tpid;
    build(0, 16'h0, 16'h0); run("R5", 2'b01, 16'h0, 2'b00, 16'h0, 1'b0, -1, -1);
    build(0, 16'h0, 16'h0); run("R5", 2'b11, 16'h7777, 2'b00, 16'h0, 1'b0, -1, -1);
  endtask

  task automatic t_inner;
    build(1, 16'h2064, 16'h0);    run("R6", 2'b00, 16'h0, 2'b10, 16'h0BCD, 1'b0, 4, 0);
    build(2, 16'h2064, 16'h3003); run("R6", 2'b00, 16'h0, 2'b01, 16'h0, 1'b0, -1, -1);
    build(2, 16'h2064, 16'h3003); run("R6", 2'b00, 16'h0, 2'b11, 16'h4C4D, 1'b0, -1, -1);
    build(1, 16'h2064, 16'h0);    run("R6", 2'b00, 16'h0, 2'b01, 16'h0, 1'b0, -1, -1);
  endtask

  task automatic t_both_levels;
    build(0, 16'h0, 16'h0);       run("R6", 2'b10, 16'h1ABC, 2'b10, 16'h2DEF, 1'b0, 8, 0);
    build(2, 16'h2064, 16'h3003); run("R6", 2'b01, 16'h0, 2'b11, 16'h5555, 1'b0, -1, -1);
  endtask

  task automatic t_sample_once;
    build(0, 16'h0, 16'h0); run("R10", 2'b10, 16'h1111, 2'b00, 16'h0, 1'b1, 4, 0);
    build(1, 16'h2064, 16'h0); run("R10", 2'b00, 16'h0, 2'b00, 16'h0, 1'b1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_keep();
    t_add();
    t_strip();
    t_swap();
    t_bad_tpid();
    t_inner();
    t_both_levels();
    t_sample_once();
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule